// File: doc/BRIEF.md
# Prioritised Fault Trap Controller

This block collects fault requests from four sources: arithmetic error, address error, stack error and oscillator failure. It picks one by fixed priority and hands the core a one-cycle take strobe with a vector number. Traps fall into two classes. The arithmetic trap is soft. The other three are hard. A hard trap holds the core stalled until the core acknowledges it. One trap is serviced at a time. Any trap that arrives while another is in service waits as pending. It is taken, highest first, once the service-complete pulse ends the current service.

A hard trap can arrive while a trap of higher priority is already pending or in service. That case is a conflict, and it is never queued. The block drops all pending and in-service state and raises a device reset request for a fixed number of cycles. It also sets a sticky conflict flag. The conflict reset does not clear that flag. Only power-on reset or an explicit clear pulse clears it.

The take strobe and vector are a plain control output with no back-pressure. The core must accept a take in the cycle it appears.

Top module: `trap_ctrl`

## Requirements
- R1: Request bits map to vectors as follows: `trap_req[0]` arithmetic gives vector 1, `trap_req[1]` address gives 2, `trap_req[2]` stack gives 3 and `trap_req[3]` oscillator gives 4. `take_vec` is 0 whenever `take` is low.
- R2: When no trap is in service, a request sampled at a clock edge produces `take` high for exactly one cycle after that edge.
- R3: Requests raised in the same cycle are resolved by priority. Oscillator is highest, then stack, then address, then arithmetic. The others stay pending and are taken later in that order.
- R4: After a hard trap is taken, `core_stall` is high from the take cycle until a `core_ack` pulse is sampled. While the trap is unacknowledged, `svc_done` has no effect.
- R5: A soft trap never raises `core_stall`. A `svc_done` pulse ends its service.
- R6: No new trap is taken while one is in service. A soft trap that arrives during hard service is taken only after that service's `svc_done`.
- R7: A conflict is a hard request that arrives while a trap of strictly higher priority is pending or in service. On a conflict, `dev_rst_req` goes high for RST_CYC cycles, starting the cycle after. All pending and in-service state is discarded.
- R8: A conflict sets `conflict_sts`. The flag persists through the conflict reset. Only `sts_clr` or `rst_n` clears it. If a conflict and `sts_clr` occur in the same cycle, the set wins.
- R9: While `dev_rst_req` is high, all trap requests are ignored. Afterwards, no take or stall results from them.
- R10: After `rst_n` is deasserted, every output is low.
- R11: Hard requests raised in the same cycle never conflict. A higher hard trap arriving over a lower pending one is not a conflict either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| trap_req | input | 4 | Per-source trap request pulses |
| core_ack | input | 1 | Core acknowledge of a hard trap |
| svc_done | input | 1 | Service-complete (return) pulse |
| sts_clr | input | 1 | Clears the sticky conflict flag |
| take | output | 1 | One-cycle trap take strobe |
| take_vec | output | 3 | Vector number of the taken trap |
| core_stall | output | 1 | Holds the core until a hard trap is acknowledged |
| dev_rst_req | output | 1 | Device reset request after a conflict |
| conflict_sts | output | 1 | Sticky conflict flag |

## Verification
The hardest situation to reach is a conflict. It needs a higher-priority trap already pending or in service at the moment a lower hard request arrives. Sparse random requests seldom line this up with ack and done timing. Directed sequences therefore first put the oscillator trap into service and then raise an address request. Other directed sequences check that same-cycle hard requests and higher-over-lower arrivals do not conflict. Random traffic with sparse requests and frequent ack and done pulses then compares every output every cycle against a bench model.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int unsigned TRAP_N    = 4;
  localparam int unsigned TRAP_SOFT = 1;
  typedef enum logic [1:0] {
    TRAP_MATH  = 2'd0,
    TRAP_ADDR  = 2'd1,
    TRAP_STACK = 2'd2,
    TRAP_OSC   = 2'd3
  } trap_id_e;
endpackage

// File: rtl/trap_prio.sv
module trap_prio #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic [N-1:0]  cand,
  output logic          any,
  output logic [IW-1:0] top
);
  always_comb begin
    any = |cand;
    top = '0;
    for (int i = 0; i < N; i++)
      if (cand[i]) top = IW'(i);
  end
endmodule

// File: rtl/trap_conflict.sv
module trap_conflict #(
  parameter int unsigned N     = 4,
  parameter int unsigned NSOFT = 1
) (
  input  logic [N-1:0] req,
  input  logic [N-1:0] busy,
  output logic         hit
);
  logic [N-1:0] per_src;
  for (genvar gi = 0; gi < N; gi++) begin : g_src
    if (gi < NSOFT) begin : g_soft
      assign per_src[gi] = 1'b0;
    end else begin : g_hard
      logic [N-1:0] above;
      assign above       = busy >> (gi + 1);
      assign per_src[gi] = req[gi] & (|above);
    end
  end
  assign hit = |per_src;
endmodule

// File: rtl/trap_rst_gen.sv
module trap_rst_gen #(
  parameter int unsigned RST_CYC = 4,
  localparam int unsigned CW     = $clog2(RST_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic clr,
  output logic rst_req,
  output logic sts
);
  logic [CW-1:0] cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sts <= 1'b0;
    end else begin
      if (fire)           cnt <= CW'(RST_CYC);
      else if (cnt != '0) cnt <= cnt - 1'b1;
      if (fire)      sts <= 1'b1;
      else if (clr)  sts <= 1'b0;
    end
  end
  assign rst_req = (cnt != '0);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sts && !clr) |=> sts);
  a_r7_reset_start: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (rst_req && sts));
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl #(
  parameter int unsigned N       = trap_pkg::TRAP_N,
  parameter int unsigned NSOFT   = trap_pkg::TRAP_SOFT,
  parameter int unsigned RST_CYC = 4,
  localparam int unsigned IW     = $clog2(N),
  localparam int unsigned VW     = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  trap_req,
  input  logic          core_ack,
  input  logic          svc_done,
  input  logic          sts_clr,
  output logic          take,
  output logic [VW-1:0] take_vec,
  output logic          core_stall,
  output logic          dev_rst_req,
  output logic          conflict_sts
);
  logic [N-1:0]  pend, busy, cand;
  logic          act, act_hard, acked;
  logic [IW-1:0] act_idx, top;
  logic          any, conf_hit, fire;

  assign busy = pend | (act ? (N'(1) << act_idx) : '0);
  assign cand = pend | trap_req;
  assign fire = conf_hit & ~dev_rst_req;

  trap_prio #(.N(N), .IW(IW)) prio_i (.cand(cand), .any(any), .top(top));
  trap_conflict #(.N(N), .NSOFT(NSOFT)) conf_i (
    .req(trap_req), .busy(busy), .hit(conf_hit));
  trap_rst_gen #(.RST_CYC(RST_CYC)) rgen_i (
    .clk(clk), .rst_n(rst_n), .fire(fire), .clr(sts_clr),
    .rst_req(dev_rst_req), .sts(conflict_sts));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0; act <= 1'b0; act_hard <= 1'b0; acked <= 1'b0;
      act_idx <= '0; take <= 1'b0; take_vec <= '0;
    end else if (dev_rst_req || fire) begin
      pend <= '0; act <= 1'b0; act_hard <= 1'b0; acked <= 1'b0;
      act_idx <= '0; take <= 1'b0; take_vec <= '0;
    end else begin
      take     <= 1'b0;
      take_vec <= '0;
      if (!act && any) begin
        take     <= 1'b1;
        take_vec <= VW'(top) + 1'b1;
        act      <= 1'b1;
        act_idx  <= top;
        act_hard <= (top >= IW'(NSOFT));
        acked    <= 1'b0;
        pend     <= cand & ~(N'(1) << top);
      end else begin
        pend <= cand;
        if (act) begin
          if (act_hard && !acked && core_ack) acked <= 1'b1;
          else if (svc_done && (!act_hard || acked)) act <= 1'b0;
        end
      end
    end
  end

  assign core_stall = act & act_hard & ~acked;

  a_r2_take_single: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);
  a_r1_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (take_vec != '0 && take_vec <= VW'(N)));
  a_r1_vec_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> (take_vec == '0));
  a_r9_quiet_reset: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst_req |-> (!take && !core_stall));
  a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (core_stall && !core_ack && !fire) |=> core_stall);
endmodule

// File: tb/trap_ctrl_tb_top.sv
module trap_ctrl_tb_top;
  localparam int RST_CYC = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] trap_req = '0;
  logic core_ack = 0, svc_done = 0, sts_clr = 0;
  logic take, core_stall, dev_rst_req, conflict_sts;
  logic [2:0] take_vec;
  int checks = 0, errors = 0;
  string cur = "R10";
  bit finished = 0;

  // bench model state
  logic [3:0] m_pend = '0;
  logic m_act = 0, m_hard = 0, m_acked = 0, m_take = 0, m_sts = 0;
  int m_idx = 0, m_vec = 0, m_rcnt = 0;

  always #10 clk = ~clk;

  trap_ctrl #(.RST_CYC(RST_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .core_ack(core_ack),
    .svc_done(svc_done), .sts_clr(sts_clr), .take(take), .take_vec(take_vec),
    .core_stall(core_stall), .dev_rst_req(dev_rst_req),
    .conflict_sts(conflict_sts));

  function automatic int top_bit(logic [3:0] v);
    int r = -1;
    for (int i = 0; i < 4; i++) if (v[i]) r = i;
    return r;
  endfunction

  function automatic bit is_conflict(logic [3:0] rq, logic [3:0] bz);
    for (int i = 1; i < 4; i++)
      for (int j = i + 1; j < 4; j++)
        if (rq[i] && bz[j]) return 1;
    return 0;
  endfunction

  task automatic chk(string tag, int act_v, int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s/%s actual=%0d expected=%0d at %0t", cur, tag, act_v, exp_v, $time);
    end
  endtask

  task automatic model_step(logic [3:0] rq, logic ak, logic dn, logic cl);
    logic [3:0] bz, p;
    int t;
    if (!rst_n) begin
      m_pend = 0; m_act = 0; m_hard = 0; m_acked = 0; m_take = 0;
      m_vec = 0; m_rcnt = 0; m_sts = 0; return;
    end
    if (m_rcnt != 0) begin
      m_rcnt--; m_pend = 0; m_act = 0; m_take = 0; m_vec = 0; m_acked = 0; m_hard = 0;
      if (cl) m_sts = 0;
      return;
    end
    bz = m_pend | (m_act ? (4'b1 << m_idx) : 4'b0);
    if (is_conflict(rq, bz)) begin
      m_rcnt = RST_CYC; m_sts = 1; m_pend = 0; m_act = 0; m_take = 0;
      m_vec = 0; m_acked = 0; m_hard = 0; return;
    end
    if (cl) m_sts = 0;
    p = m_pend | rq; m_take = 0; m_vec = 0;
    t = top_bit(p);
    if (!m_act && t >= 0) begin
      m_take = 1; m_vec = t + 1; m_act = 1; m_idx = t; m_hard = (t >= 1);
      m_acked = 0; m_pend = p & ~(4'b1 << t);
    end else begin
      m_pend = p;
      if (m_act) begin
        if (m_hard && !m_acked && ak) m_acked = 1;
        else if (dn && (!m_hard || m_acked)) m_act = 0;
      end
    end
  endtask

  task automatic cyc(logic [3:0] rq, logic ak = 0, logic dn = 0, logic cl = 0);
    @(negedge clk);
    chk("R2", take, m_take);
    chk("R1", take_vec, m_vec);
    chk("R4", core_stall, m_act && m_hard && !m_acked);
    chk("R7", dev_rst_req, m_rcnt != 0);
    chk("R8", conflict_sts, m_sts);
    trap_req = rq; core_ack = ak; svc_done = dn; sts_clr = cl;
    model_step(rq, ak, dn, cl);
    @(posedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    cur = "R10"; cyc(0); cyc(0);
    @(negedge clk); rst_n = 1;
    cyc(0); cyc(0);
    cur = "R2"; cyc(4'b0100); cyc(0); cyc(0, 1); cyc(0, 0, 1); cyc(0);
    cur = "R3"; cyc(4'b1010); cyc(0); cyc(0, 1); cyc(0, 0, 1); cyc(0);
    cyc(0, 1); cyc(0, 0, 1); cyc(0);
    cur = "R4"; cyc(4'b0010); cyc(0, 0, 1); cyc(0, 0, 1); cyc(0, 1); cyc(0, 0, 1); cyc(0);
    cur = "R5"; cyc(4'b0001); cyc(0); cyc(0, 0, 1); cyc(0);
    cur = "R6"; cyc(4'b0010); cyc(4'b0001); cyc(0, 1); cyc(0); cyc(0, 0, 1); cyc(0);
    cyc(0, 0, 1); cyc(0);
    cur = "R11"; cyc(4'b0110); cyc(0); cyc(0, 1); cyc(0, 0, 1); cyc(0);
    cyc(0, 1); cyc(0, 0, 1); cyc(0);
    cyc(4'b0010); cyc(4'b1000); cyc(0, 1); cyc(0, 0, 1); cyc(0); cyc(0, 1); cyc(0, 0, 1); cyc(0);
    cur = "R7"; cyc(4'b1000); cyc(0); cyc(4'b0010); cyc(0);
    cur = "R9"; cyc(4'b1111); cyc(4'b0100); cyc(0); cyc(0); cyc(0); cyc(0);
    cur = "R8"; cyc(0); cyc(0, 0, 0, 1); cyc(0);
    cyc(4'b1000); cyc(4'b0100, 0, 0, 1); for (int k = 0; k < RST_CYC + 2; k++) cyc(0);
    cyc(0, 0, 0, 1); cyc(0);
    cur = "rand";
    for (int k = 0; k < 4000; k++) begin
      logic [3:0] rq;
      for (int b = 0; b < 4; b++) rq[b] = ($urandom % 20) == 0;
      cyc(rq, ($urandom % 3) == 0, ($urandom % 3) == 0, ($urandom % 40) == 0);
    end
    cyc(0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule